// File: doc/BRIEF.md
# Mirrored-Memory Swap-and-Compare Refresh Sequencer

This block keeps two single-bit-wide memories, called copy A and copy B, continuously exercised. The two copies are meant to hold the same data. They sit on one shared address bus and one shared one-bit data line. The sequencer runs on its own from reset and has no command inputs. It steps through every address in turn and gives each address a fixed slot of eight ticks.

Within one slot the sequencer does the following. It parks B's bit in a one-bit holding register. It lets A drive the line so that B takes A's bit. It then drives the held bit back onto the line so that A takes B's former bit. While A is driving, the line is compared with the held bit. A difference sets a sticky error flag and records the address that failed first.

The block is clocked at twice the nominal controller rate, so that each tick is one half-cycle phase. The output enables never overlap. Each write strobe falls inside the phase in which its data source has already been driving for a full tick. The address advances only after all writes of the slot are done.

Top module: `mirror_scrub_seq`

## Requirements
- R1: After reset the address is 0, the phase is 0, the error flag and the captured error address are 0, and the holding register holds 0.
- R2: The phase steps 0,1,2,...,7,0 on every tick with no other ordering. Every output is a function of the phase alone, apart from the address, the held bit and the error outputs.
- R3: `rd_en_b` is high in phases 0 and 1, `rd_en_a` in phases 2 and 3, and `hold_drv` in phases 4 and 5. At most one of these three is high on any tick.
- R4: `hold_cap` is high only in phase 1. At the tick that ends phase 1, the holding register loads the data line, and `hold_bit` shows that value until the next capture.
- R5: `wr_en_b` is high only in phase 3, while A drives the line. `wr_en_a` is high only in phase 5, while the holding register drives the line.
- R6: `adv_addr` is high only in phase 6. The address rises by one at the tick that ends phase 6, wraps from 2^ADDR_W-1 to 0, and is otherwise unchanged.
- R7: `cmp_stb` is high only in phase 3. If the data line differs from `hold_bit` there, `err` is high from the next tick.
- R8: Once set, `err` stays high and `err_addr` keeps the address of the first mismatch until reset. Later mismatches do not change `err_addr`.
- R9: After one full pass over all addresses from reset, copy A holds what copy B held before the pass, and copy B holds what copy A held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one tick per half controller cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Value currently on the shared data line |
| rd_en_a | output | 1 | Output enable of copy A |
| rd_en_b | output | 1 | Output enable of copy B |
| wr_en_a | output | 1 | Write enable of copy A |
| wr_en_b | output | 1 | Write enable of copy B |
| hold_cap | output | 1 | Capture enable of the holding register |
| hold_drv | output | 1 | Enable of the holding register's line driver |
| hold_bit | output | 1 | Held bit, for the line driver |
| adv_addr | output | 1 | Address counter advance strobe |
| addr | output | ADDR_W | Shared address to both copies |
| cmp_stb | output | 1 | Compare strobe |
| err | output | 1 | Sticky copy-mismatch flag |
| err_addr | output | ADDR_W | Address of the first mismatch |

## Verification
The bench builds the sequencer with ADDR_W set to 5. With 32 addresses, a full pass takes 256 ticks, so the bench can cover several complete passes, the address wrap and repeated reset within a short run. It seeds deliberate differences between the copies at two addresses. This shows that the first failing address is latched and the second is ignored. It also shows that a full pass leaves the two copies exchanged, which exercises both write paths and the holding register.

// File: rtl/mscr_pkg.sv
package mscr_pkg;

    localparam int PHASE_W   = 3;
    localparam int PHASE_CNT = 1 << PHASE_W;

    typedef enum logic [PHASE_W-1:0] {
        PH_RD_B0  = 3'd0,
        PH_RD_B1  = 3'd1,
        PH_RD_A0  = 3'd2,
        PH_RD_A1  = 3'd3,
        PH_DRV_H0 = 3'd4,
        PH_DRV_H1 = 3'd5,
        PH_ADV    = 3'd6,
        PH_IDLE   = 3'd7
    } phase_e;

    typedef struct packed {
        logic rd_a;
        logic rd_b;
        logic wr_a;
        logic wr_b;
        logic cap;
        logic drv;
        logic adv;
        logic cmp;
    } ctl_t;

endpackage

// File: rtl/mscr_phase_seq.sv
module mscr_phase_seq
    import mscr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o
);

    typedef struct packed {
        phase_e phase;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.phase = phase_e'(st_q.phase + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_RD_B0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

endmodule

// File: rtl/mscr_ctl_decode.sv
module mscr_ctl_decode
    import mscr_pkg::*;
(
    input  phase_e phase_i,
    output ctl_t   ctl_o
);

    always_comb begin
        ctl_o = '0;
        unique case (phase_i)
            PH_RD_B0:  ctl_o.rd_b = 1'b1;
            PH_RD_B1: begin
                ctl_o.rd_b = 1'b1;
                ctl_o.cap  = 1'b1;
            end
            PH_RD_A0:  ctl_o.rd_a = 1'b1;
            PH_RD_A1: begin
                ctl_o.rd_a = 1'b1;
                ctl_o.wr_b = 1'b1;
                ctl_o.cmp  = 1'b1;
            end
            PH_DRV_H0: ctl_o.drv = 1'b1;
            PH_DRV_H1: begin
                ctl_o.drv  = 1'b1;
                ctl_o.wr_a = 1'b1;
            end
            PH_ADV:    ctl_o.adv = 1'b1;
            PH_IDLE:   ctl_o = '0;
            default:   ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/mscr_hold_reg.sv
module mscr_hold_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    input  logic bus_i,
    output logic hold_o
);

    typedef struct packed {
        logic bit_v;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.bit_v = bus_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.bit_v;

endmodule

// File: rtl/mscr_addr_ctr.sv
module mscr_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.addr = st_q.addr + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

endmodule

// File: rtl/mscr_err_trap.sv
module mscr_err_trap #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_i,
    input  logic              bus_i,
    input  logic              hold_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              err_o,
    output logic [ADDR_W-1:0] err_addr_o
);

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] where;
    } trap_t;

    trap_t st_d, st_q;
    logic  miss;

    always_comb begin
        miss = cmp_i && (bus_i != hold_i);
        st_d = st_q;
        if (miss && !st_q.flag) begin
            st_d.flag  = 1'b1;
            st_d.where = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o      = st_q.flag;
    assign err_addr_o = st_q.where;

endmodule

// File: rtl/mirror_scrub_seq.sv
module mirror_scrub_seq
    import mscr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_i,
    output logic              rd_en_a,
    output logic              rd_en_b,
    output logic              wr_en_a,
    output logic              wr_en_b,
    output logic              hold_cap,
    output logic              hold_drv,
    output logic              hold_bit,
    output logic              adv_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              cmp_stb,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr
);

    phase_e phase;
    ctl_t   ctl;

    mscr_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    mscr_ctl_decode u_dec (
        .phase_i (phase),
        .ctl_o   (ctl)
    );

    mscr_hold_reg u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (ctl.cap),
        .bus_i  (bus_i),
        .hold_o (hold_bit)
    );

    mscr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (ctl.adv),
        .addr_o (addr)
    );

    mscr_err_trap #(.ADDR_W(ADDR_W)) u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_i      (ctl.cmp),
        .bus_i      (bus_i),
        .hold_i     (hold_bit),
        .addr_i     (addr),
        .err_o      (err),
        .err_addr_o (err_addr)
    );

    assign rd_en_a  = ctl.rd_a;
    assign rd_en_b  = ctl.rd_b;
    assign wr_en_a  = ctl.wr_a;
    assign wr_en_b  = ctl.wr_b;
    assign hold_cap = ctl.cap;
    assign hold_drv = ctl.drv;
    assign adv_addr = ctl.adv;
    assign cmp_stb  = ctl.cmp;

endmodule

// File: rtl/mscr_chk.sv
module mscr_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_a,
    input logic              rd_en_b,
    input logic              wr_en_a,
    input logic              wr_en_b,
    input logic              hold_cap,
    input logic              hold_drv,
    input logic              adv_addr,
    input logic [ADDR_W-1:0] addr,
    input logic              cmp_stb,
    input logic              err,
    input logic [ADDR_W-1:0] err_addr
);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en_a, rd_en_b, hold_drv})); // R3

    AST_CAP_WHILE_B: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cap |-> rd_en_b); // R4

    AST_WR_B_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_b |-> (rd_en_a && $past(rd_en_a))); // R5

    AST_WR_A_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_a |-> (hold_drv && $past(hold_drv))); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_addr |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R6

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_addr |=> $stable(addr)); // R6

    AST_CMP_WHILE_A: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_stb |-> rd_en_a); // R7

    AST_ERR_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(cmp_stb)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(err_addr))); // R8

endmodule

bind mirror_scrub_seq mscr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en_a  (rd_en_a),
    .rd_en_b  (rd_en_b),
    .wr_en_a  (wr_en_a),
    .wr_en_b  (wr_en_b),
    .hold_cap (hold_cap),
    .hold_drv (hold_drv),
    .adv_addr (adv_addr),
    .addr     (addr),
    .cmp_stb  (cmp_stb),
    .err      (err),
    .err_addr (err_addr)
);

// File: tb/mirror_scrub_seq_tb.sv
module mirror_scrub_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int N          = 1 << ADDR_W;
    localparam int SLOT       = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus;
    logic              rd_en_a, rd_en_b, wr_en_a, wr_en_b;
    logic              hold_cap, hold_drv, hold_bit, adv_addr, cmp_stb, err;
    logic [ADDR_W-1:0] addr, err_addr;

    logic mem_a [N];
    logic mem_b [N];
    logic save_a [N];
    logic save_b [N];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_phase = 0;
    int m_addr  = 0;
    bit m_hold  = 1'b0;
    bit m_err   = 1'b0;
    int m_eaddr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus = rd_en_b ? mem_b[addr] :
                 rd_en_a ? mem_a[addr] :
                 hold_drv ? hold_bit : 1'b0;

    always @(posedge clk) begin
        if (wr_en_a) mem_a[addr] <= bus;
        if (wr_en_b) mem_b[addr] <= bus;
    end

    mirror_scrub_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_i    (bus),
        .rd_en_a  (rd_en_a),
        .rd_en_b  (rd_en_b),
        .wr_en_a  (wr_en_a),
        .wr_en_b  (wr_en_b),
        .hold_cap (hold_cap),
        .hold_drv (hold_drv),
        .hold_bit (hold_bit),
        .adv_addr (adv_addr),
        .addr     (addr),
        .cmp_stb  (cmp_stb),
        .err      (err),
        .err_addr (err_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: checks outputs against the current model state, then advances it
    always @(negedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_hold = 1'b0; m_err = 1'b0; m_eaddr = 0;
            chk(int'(addr) == 0, "R1 addr", int'(addr), 0);
            chk(err == 1'b0, "R1 err", int'(err), 0);
            chk(int'(err_addr) == 0, "R1 err_addr", int'(err_addr), 0);
            chk(hold_bit == 1'b0, "R1 hold_bit", int'(hold_bit), 0);
        end else begin
            chk(rd_en_b == (m_phase < 2), "R3 rd_en_b", int'(rd_en_b), int'(m_phase < 2));
            chk(rd_en_a == (m_phase == 2 || m_phase == 3), "R3 rd_en_a",
                int'(rd_en_a), int'(m_phase == 2 || m_phase == 3));
            chk(hold_drv == (m_phase == 4 || m_phase == 5), "R3 hold_drv",
                int'(hold_drv), int'(m_phase == 4 || m_phase == 5));
            chk(int'(rd_en_a) + int'(rd_en_b) + int'(hold_drv) <= 1, "R3 contention",
                int'(rd_en_a) + int'(rd_en_b) + int'(hold_drv), 1);
            chk(hold_cap == (m_phase == 1), "R4 hold_cap", int'(hold_cap), int'(m_phase == 1));
            chk(hold_bit == m_hold, "R4 hold_bit", int'(hold_bit), int'(m_hold));
            chk(wr_en_b == (m_phase == 3), "R5 wr_en_b", int'(wr_en_b), int'(m_phase == 3));
            chk(wr_en_a == (m_phase == 5), "R5 wr_en_a", int'(wr_en_a), int'(m_phase == 5));
            chk(adv_addr == (m_phase == 6), "R6 adv_addr", int'(adv_addr), int'(m_phase == 6));
            chk(int'(addr) == m_addr, "R6 addr", int'(addr), m_addr);
            chk(cmp_stb == (m_phase == 3), "R7 cmp_stb", int'(cmp_stb), int'(m_phase == 3));
            chk(err == m_err, "R7 err", int'(err), int'(m_err));
            if (m_err) chk(int'(err_addr) == m_eaddr, "R8 err_addr", int'(err_addr), m_eaddr);
            // R2: phase loop advances every tick
            if (m_phase == 1) m_hold = mem_b[m_addr];
            if (m_phase == 3 && !m_err && (mem_a[m_addr] != m_hold)) begin
                m_err = 1'b1;
                m_eaddr = m_addr;
            end
            if (m_phase == 6) m_addr = (m_addr + 1) % N;
            m_phase = (m_phase + 1) % SLOT;
        end
    end

    task automatic pulse_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic snapshot();
        for (int i = 0; i < N; i++) begin
            save_a[i] = mem_a[i];
            save_b[i] = mem_b[i];
        end
    endtask

    task automatic run_pass_and_check_swap(input string tag);
        snapshot();
        repeat (SLOT * N) @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            chk(mem_a[i] == save_b[i], tag, int'(mem_a[i]), int'(save_b[i]));
            chk(mem_b[i] == save_a[i], tag, int'(mem_b[i]), int'(save_a[i]));
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mem_b[i] = ((i * 7 + 3) % 5) < 2;
            mem_a[i] = mem_b[i];
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 with equal copies: two passes, copies unchanged, no error
        run_pass_and_check_swap("R9 equal pass1");
        run_pass_and_check_swap("R9 equal pass2");
        chk(err == 1'b0, "R7 no mismatch", int'(err), 0);

        // seeded mismatches at two addresses, first one latched
        pulse_reset();
        mem_a[9]  = ~mem_a[9];
        mem_a[20] = ~mem_a[20];
        run_pass_and_check_swap("R9 swap with faults");
        @(negedge clk); #1;
        chk(err == 1'b1, "R7 mismatch flagged", int'(err), 1);
        chk(int'(err_addr) == 9, "R8 first failing address", int'(err_addr), 9);
        repeat (SLOT * N / 2) @(posedge clk);
        #1;
        chk(err == 1'b1 && int'(err_addr) == 9, "R8 sticky", int'(err_addr), 9);

        // reset clears the sticky flag
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk); #1;
        chk(err == 1'b0, "R1 err cleared by reset", int'(err), 0);
        chk(int'(addr) == 0, "R1 addr cleared by reset", int'(addr), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (SLOT * 3) @(posedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule